// File: doc/BRIEF.md
# Sliding Window SAD Engine

This block serves a motion-estimation search. Each accepted input carries one 4-pixel row of a reference block and one 8-pixel row taken from the search frame at the same vertical position. Inside the wider search row the engine places a 4-pixel window at every whole-pixel horizontal shift (0 through 4). For every shift it forms the sum of absolute differences against the reference row. All window positions are served from the one wide slice in parallel, so the caller never issues a misaligned fetch.

The per-shift row sums are added up over the four rows of a 4x4 block. A block opens with a row flagged as the first row. After the fourth row has been taken, the engine raises a one-cycle completion pulse and presents the five block totals on a registered output. That output holds its value until the next block completes. Rows are transferred on a valid/ready handshake at a rate of up to one per cycle, and a new block may start in the cycle right after the previous block's last row.

Top module: `sad_window_engine`

## Requirements
- R1: While `rst` is high, `in_ready` and `done` are 0 and `sad_out` is all zeros. From the first cycle after reset is released, `in_ready` is 1.
- R2: Pixel i of `ref_row` occupies bits [8i+7:8i], and pixel j of `srch_row` occupies bits [8j+7:8j]. Pixels are unsigned 8-bit values. For shift k, the row sum is the total over i=0..3 of |ref[i] - srch[k+i]|.
- R3: The block total for shift k is the sum of its row sums over the four accepted rows of the block. It appears in `sad_out` bits [12k+11:12k], for k = 0..4.
- R4: A row accepted with `in_first` high discards any partial block and starts a new block, with that row counted as row 0.
- R5: `done` is high for exactly one cycle: the cycle after the fourth row of a block is accepted. In that cycle `sad_out` carries that block's totals.
- R6: `sad_out` changes only in a cycle where `done` is high, and otherwise holds its last value.
- R7: A cycle with `in_valid` low transfers no row, whatever the data inputs carry. Idle cycles between the rows of a block leave its totals unchanged.
- R8: A row accepted with `in_first` low while no block is open is ignored. It produces no `done` and no change to `sad_out`.
- R9: The block totals do not wrap. The largest input pattern gives 4080 (0xFF0) per shift.
- R10: A new block's first row may be accepted in the cycle right after the previous block's fourth row. Both blocks still report correct totals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A row is offered this cycle |
| in_ready | output | 1 | Engine can take a row this cycle |
| in_first | input | 1 | The offered row is row 0 of a new block |
| ref_row | input | 32 | Four reference pixels, pixel 0 in the low byte |
| srch_row | input | 64 | Eight search pixels, pixel 0 in the low byte |
| done | output | 1 | One-cycle pulse: block totals are presented |
| sad_out | output | 60 | Five 12-bit block totals, shift 0 in the low field |

## Verification
Getting a field-position or window-offset fault to show at the ports is the hardest part. Random pixel data blurs the five totals together, so a swapped window can pass unnoticed. The stimulus therefore sweeps a single non-zero search pixel across all eight positions against an all-zero reference. Each sweep lights exactly the shifts whose windows cover that pixel. Separate sequences cover the other cases: first rows that abort a half-finished block, stray rows with no block open, invalid cycles carrying data between rows, and blocks sent back to back.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned DEF_PIX_W     = 8;
  localparam int unsigned DEF_ROW_PIX   = 4;
  localparam int unsigned DEF_SLICE_PIX = 8;
  localparam int unsigned DEF_ROWS      = 4;

  typedef enum logic {BLK_IDLE = 1'b0, BLK_OPEN = 1'b1} blk_state_t;
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  output logic [PIX_W-1:0] d
);
  always_comb begin
    if (a >= b) d = a - b;
    else        d = b - a;
  end
endmodule

// File: rtl/sad_row_unit.sv
module sad_row_unit #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned ROW_PIX = 4,
  parameter int unsigned OUT_W   = PIX_W + $clog2(ROW_PIX)
) (
  input  logic [ROW_PIX*PIX_W-1:0] ref_px,
  input  logic [ROW_PIX*PIX_W-1:0] win_px,
  output logic [OUT_W-1:0]         row_sad
);
  logic [PIX_W-1:0] diffs [ROW_PIX];

  for (genvar i = 0; i < ROW_PIX; i++) begin : g_pair
    sad_absdiff #(.PIX_W(PIX_W)) u_ad (
      .a(ref_px[i*PIX_W +: PIX_W]),
      .b(win_px[i*PIX_W +: PIX_W]),
      .d(diffs[i])
    );
  end

  always_comb begin
    row_sad = '0;
    for (int i = 0; i < ROW_PIX; i++) begin
      row_sad = row_sad + OUT_W'(diffs[i]);
    end
  end
endmodule

// File: rtl/sad_acc_bank.sv
module sad_acc_bank
  import sad_pkg::*;
#(
  parameter int unsigned NUM_OFF   = 5,
  parameter int unsigned ROW_SAD_W = 10,
  parameter int unsigned ACC_W     = 12,
  parameter int unsigned ROWS      = 4,
  localparam int unsigned CNT_W    = $clog2(ROWS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        take_row,
  input  logic                        first,
  input  logic [NUM_OFF*ROW_SAD_W-1:0] row_sads,
  output logic                        done,
  output logic [NUM_OFF*ACC_W-1:0]    totals
);
  blk_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q   [NUM_OFF];
  logic [ACC_W-1:0] acc_nxt [NUM_OFF];
  logic             use_row;
  logic             last_row;

  assign use_row  = take_row && (first || (st_q == BLK_OPEN));
  assign last_row = use_row &&
                    (first ? (ROWS == 1) : (cnt_q == CNT_W'(ROWS - 1)));

  for (genvar k = 0; k < NUM_OFF; k++) begin : g_acc
    always_comb begin
      acc_nxt[k] = (first ? '0 : acc_q[k]) +
                   ACC_W'(row_sads[k*ROW_SAD_W +: ROW_SAD_W]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[k] <= '0;
      end else if (use_row) begin
        acc_q[k] <= acc_nxt[k];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        totals[k*ACC_W +: ACC_W] <= '0;
      end else if (last_row) begin
        totals[k*ACC_W +: ACC_W] <= acc_nxt[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= BLK_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_row;
      if (use_row) begin
        if (last_row) begin
          st_q  <= BLK_IDLE;
          cnt_q <= '0;
        end else begin
          st_q  <= BLK_OPEN;
          cnt_q <= first ? CNT_W'(1) : cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sad_window_engine.sv
module sad_window_engine
  import sad_pkg::*;
#(
  parameter int unsigned PIX_W     = DEF_PIX_W,
  parameter int unsigned ROW_PIX   = DEF_ROW_PIX,
  parameter int unsigned SLICE_PIX = DEF_SLICE_PIX,
  parameter int unsigned ROWS      = DEF_ROWS,
  localparam int unsigned NUM_OFF   = SLICE_PIX - ROW_PIX + 1,
  localparam int unsigned ROW_SAD_W = PIX_W + $clog2(ROW_PIX),
  localparam int unsigned ACC_W     = ROW_SAD_W + $clog2(ROWS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_first,
  input  logic [ROW_PIX*PIX_W-1:0]     ref_row,
  input  logic [SLICE_PIX*PIX_W-1:0]   srch_row,
  output logic                         done,
  output logic [NUM_OFF*ACC_W-1:0]     sad_out
);
  logic [NUM_OFF*ROW_SAD_W-1:0] row_sads;
  logic                         take_row;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  assign take_row = in_valid && in_ready;

  for (genvar k = 0; k < NUM_OFF; k++) begin : g_off
    sad_row_unit #(
      .PIX_W  (PIX_W),
      .ROW_PIX(ROW_PIX),
      .OUT_W  (ROW_SAD_W)
    ) u_row (
      .ref_px (ref_row),
      .win_px (srch_row[k*PIX_W +: ROW_PIX*PIX_W]),
      .row_sad(row_sads[k*ROW_SAD_W +: ROW_SAD_W])
    );
  end

  sad_acc_bank #(
    .NUM_OFF  (NUM_OFF),
    .ROW_SAD_W(ROW_SAD_W),
    .ACC_W    (ACC_W),
    .ROWS     (ROWS)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .take_row(take_row),
    .first   (in_first),
    .row_sads(row_sads),
    .done    (done),
    .totals  (sad_out)
  );
endmodule

// File: rtl/sad_window_engine_chk.sv
module sad_window_engine_chk #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned ROW_PIX = 4,
  parameter int unsigned ROWS    = 4,
  parameter int unsigned NUM_OFF = 5,
  parameter int unsigned ACC_W   = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     done,
  input logic [NUM_OFF*ACC_W-1:0] sad_out
);
  localparam int unsigned MAX_TOT = ROWS * ROW_PIX * ((1 << PIX_W) - 1);

  logic in_range;
  always_comb begin
    in_range = 1'b1;
    for (int k = 0; k < NUM_OFF; k++) begin
      if (32'(sad_out[k*ACC_W +: ACC_W]) > MAX_TOT) in_range = 1'b0;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!in_ready && !done && sad_out == '0));

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready);

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_follows_accept_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid && in_ready));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sad_out));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    in_range);
endmodule

bind sad_window_engine sad_window_engine_chk #(
  .PIX_W  (PIX_W),
  .ROW_PIX(ROW_PIX),
  .ROWS   (ROWS),
  .NUM_OFF(NUM_OFF),
  .ACC_W  (ACC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .done    (done),
  .sad_out (sad_out)
);

// File: tb/sim_sad_window_engine.sv
`timescale 1ns/1ps
module sim_sad_window_engine;
  localparam int NOFF = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_first = 1'b0;
  logic [31:0] ref_row = '0;
  logic [63:0] srch_row = '0;
  logic        in_ready;
  logic        done;
  logic [59:0] sad_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2.5 clk = ~clk;

  sad_window_engine u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .ref_row(ref_row), .srch_row(srch_row),
    .done(done), .sad_out(sad_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic int row_sum(logic [31:0] r, logic [63:0] s, int k);
    int t = 0;
    for (int i = 0; i < 4; i++) begin
      int a = int'(r[8*i +: 8]);
      int b = int'(s[8*(k+i) +: 8]);
      t += (a > b) ? a - b : b - a;
    end
    return t;
  endfunction

  task automatic chk(string req, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit f, logic [31:0] r, logic [63:0] s);
    in_valid = v; in_first = f; ref_row = r; srch_row = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [59:0] expect_tot(logic [31:0] refs[4], logic [63:0] srchs[4]);
    logic [59:0] e = '0;
    for (int k = 0; k < NOFF; k++) begin
      int t = 0;
      for (int r = 0; r < 4; r++) t += row_sum(refs[r], srchs[r], k);
      e[12*k +: 12] = 12'(t);
    end
    return e;
  endfunction

  // Sends a complete block; gap = invalid cycles between rows (R7).
  task automatic run_block(logic [31:0] refs[4], logic [63:0] srchs[4],
                           int gap, bit idle_after, string req);
    logic [59:0] e = expect_tot(refs, srchs);
    logic [59:0] held;
    for (int r = 0; r < 4; r++) begin
      step(1'b1, r == 0, refs[r], srchs[r]);
      if (r < 3) begin
        chk("R5 early done", done == 1'b0, 64'(done), 64'd0);
        for (int g = 0; g < gap; g++) begin
          step(1'b0, 1'b1, rnd(), {rnd(), rnd()});
          chk("R7 gap no done", done == 1'b0, 64'(done), 64'd0);
        end
      end
    end
    chk("R5 done after row 4", done == 1'b1, 64'(done), 64'd1);
    chk(req, sad_out == e, 64'(sad_out), 64'(e));
    if (idle_after) begin
      held = sad_out;
      step(1'b0, 1'b0, rnd(), {rnd(), rnd()});
      chk("R5 single pulse", done == 1'b0, 64'(done), 64'd0);
      chk("R6 hold", sad_out == held, 64'(sad_out), 64'(held));
    end
  endtask

  initial begin
    logic [31:0] refs[4];
    logic [63:0] srchs[4];
    logic [59:0] held;
    logic [59:0] e;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 ready in reset", in_ready == 1'b0, 64'(in_ready), 64'd0);
    chk("R1 done in reset", done == 1'b0, 64'(done), 64'd0);
    chk("R1 sad in reset", sad_out == '0, 64'(sad_out), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", in_ready == 1'b1, 64'(in_ready), 64'd1);

    // R2: single lit pixel swept over every search position and level
    foreach (refs[r]) refs[r] = '0;
    for (int j = 0; j < 8; j++) begin
      for (int v = 1; v < 256; v += 37) begin
        foreach (srchs[r]) srchs[r] = 64'(v) << (8*j);
        run_block(refs, srchs, 0, 1'b1, "R2 window position");
      end
    end

    // R9: extreme values, both directions
    foreach (refs[r]) begin refs[r] = '0; srchs[r] = '1; end
    run_block(refs, srchs, 0, 1'b1, "R9 max totals");
    chk("R9 field value", sad_out[11:0] == 12'hFF0, 64'(sad_out[11:0]), 64'hFF0);
    foreach (refs[r]) begin refs[r] = '1; srchs[r] = '0; end
    run_block(refs, srchs, 1, 1'b1, "R9 max totals reversed");

    // R3/R7/R10: random blocks, with gaps, and back to back
    for (int b = 0; b < 60; b++) begin
      foreach (refs[r]) begin refs[r] = rnd(); srchs[r] = {rnd(), rnd()}; end
      if (b % 3 == 0)      run_block(refs, srchs, 2, 1'b1, "R7 totals with gaps");
      else if (b % 3 == 1) run_block(refs, srchs, 0, 1'b0, "R10 back to back");
      else                 run_block(refs, srchs, 0, 1'b1, "R3 random totals");
    end
    step(1'b0, 1'b0, '0, '0);

    // R8: stray rows with no open block
    held = sad_out;
    for (int r = 0; r < 6; r++) begin
      step(1'b1, 1'b0, rnd(), {rnd(), rnd()});
      chk("R8 stray no done", done == 1'b0, 64'(done), 64'd0);
    end
    chk("R8 stray no change", sad_out == held, 64'(sad_out), 64'(held));

    // R4: partial block aborted by a new first row
    step(1'b1, 1'b1, '0, '1);
    step(1'b1, 1'b0, '0, '1);
    foreach (refs[r]) begin refs[r] = rnd(); srchs[r] = {rnd(), rnd()}; end
    run_block(refs, srchs, 0, 1'b1, "R4 restart discards partial");
    // R4: first row arriving as the fourth row restarts
    step(1'b1, 1'b1, '0, '1);
    step(1'b1, 1'b0, '0, '1);
    step(1'b1, 1'b0, '0, '1);
    e = sad_out;
    run_block(refs, srchs, 0, 1'b1, "R4 restart at row 3");
    chk("R4 same totals", sad_out == e, 64'(sad_out), 64'(e));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule